// File: doc/BRIEF.md
# Edge-Detecting Input Synchronizer

This block takes a single-bit signal that has no timing relation to the local clock, such as a push-button or a serial data line, and carries it safely into the destination clock domain. It passes the raw signal through a configurable chain of flip-flops, all clocked by the destination clock. It then feeds the settled value into a two-state level tracker. The tracker drives a clean level output and one-cycle strobes that mark rising edges, falling edges, or either kind.

The tracker has two states. In `LVL_LOW` the last accepted level is 0. In `LVL_HIGH` it is 1. Transition `T_RISE` moves from `LVL_LOW` to `LVL_HIGH` when the last chain stage reads 1. Transition `T_FALL` moves from `LVL_HIGH` to `LVL_LOW` when it reads 0. Otherwise the state holds. Reset forces `LVL_LOW` and clears the chain.

A strobe is decoded from the state and the last chain stage, so it appears in the cycle before the level output changes. The latency is fixed. Let E1 be the first destination rising edge that samples a new input value. The strobe is high for the one cycle that follows edge E(N), where N is `SYNC_STAGES`. The level output takes the new value at edge E(N+1). With the default of two stages, the level trails the input by three edges. Input pulses narrower than about two destination periods may be lost, so callers should keep pulses wider than that.

Top module: `esync_top`

## Requirements
- R1: While reset is active, and on the first cycle after any clock edge at which reset was active, `level_o`, `rise_o`, `fall_o` and `edge_o` are all 0. Reset is synchronous and clears every flop to 0, which puts the tracker in `LVL_LOW`.
- R2: A 0-to-1 change of `async_i` first sampled at edge E1 drives `rise_o` high for exactly the one cycle after edge E(N), where N = `SYNC_STAGES`.
- R3: A 1-to-0 change of `async_i` first sampled at edge E1 drives `fall_o` high for exactly the one cycle after edge E(N).
- R4: `edge_o` is high exactly when one of `rise_o` or `fall_o` is high. `rise_o` and `fall_o` are never high together.
- R5: `level_o` takes the new sampled value at edge E(N+1). It rises only in the cycle after a `rise_o` cycle and falls only in the cycle after a `fall_o` cycle.
- R6: Each transition of the sampled input gives exactly one strobe of the matching kind. A steady input gives no strobe.
- R7: `RST_ACTIVE_HIGH` = 1 makes `rst_i` = 1 the reset state. `RST_ACTIVE_HIGH` = 0 makes `rst_i` = 0 the reset state.
- R8: `SYNC_STAGES` sets the chain length and therefore the strobe and level latency. A value below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination clock |
| rst_i | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_HIGH` |
| async_i | input | 1 | Raw signal with no timing relation to `clk_i` |
| level_o | output | 1 | Synchronized level (tracker state, 1 = `LVL_HIGH`) |
| rise_o | output | 1 | One-cycle strobe on a 0-to-1 transition |
| fall_o | output | 1 | One-cycle strobe on a 1-to-0 transition |
| edge_o | output | 1 | One-cycle strobe on either transition |

## Verification
A stuck or wrongly cleared chain stage shows up at the ports as a strobe that comes one or more cycles early or late, or does not come at all. The bench compares every cycle against an arithmetic pipeline model, so such a fault is seen within N+1 edges of the first input change. A tracker state that disagrees with the chain shows up as a doubled or missing strobe, or as `level_o` moving without a strobe the cycle before. Comparing the strobe counts with the count of sampled input transitions also exposes any lost or extra event. Two configurations are swept: two stages with a high-active reset, and three stages with a low-active reset.

// File: rtl/esync_pkg.sv
package esync_pkg;

    // Tracker state: value of the edge flop that follows the chain
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/esync_chain.sv
module esync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[LAST];

    // R1: a clear leaves every stage at zero on the next cycle
    p_chain_clear_r1: assert property (@(posedge clk_i)
        clr_i |=> (stg_q == '0));

    // R2/R3: the last stage only ever takes a value the previous stage held
    p_chain_order_r2: assert property (@(posedge clk_i) disable iff (clr_i)
        !$stable(q_o) |-> (q_o == $past(stg_q[LAST-1])));

endmodule

// File: rtl/esync_edge_fsm.sv
module esync_edge_fsm
    import esync_pkg::*;
(
    input  logic clk_i,
    input  logic clr_i,
    input  logic sync_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o,
    output logic edge_o
);

    lvl_state_t state_q;
    lvl_state_t state_d;

    // Next-state decode: T_RISE and T_FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (sync_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!sync_i) state_d = LVL_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        level_o = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                rise_o = sync_i;
            end
            LVL_HIGH: begin
                level_o = 1'b1;
                fall_o  = !sync_i;
            end
        endcase
        edge_o = rise_o | fall_o;
    end

    // R4: the two edge kinds exclude each other
    p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (clr_i)
        $onehot0({rise_o, fall_o}));

    // R4: any-edge strobe always has exactly one cause
    p_any_edge_r4: assert property (@(posedge clk_i) disable iff (clr_i)
        edge_o |-> (rise_o ^ fall_o));

    // R5: the level follows a strobe one cycle later
    p_rise_level_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        rise_o |=> level_o);

    p_fall_level_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        fall_o |=> !level_o);

    // R5: the level never moves without a preceding strobe
    p_level_rose_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(level_o) |-> $past(rise_o));

    p_level_fell_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        $fell(level_o) |-> $past(fall_o));

    // R2/R3: a strobe never lasts two cycles
    p_single_rise_r2: assert property (@(posedge clk_i) disable iff (clr_i)
        rise_o |=> !rise_o);

    p_single_fall_r3: assert property (@(posedge clk_i) disable iff (clr_i)
        fall_o |=> !fall_o);

endmodule

// File: rtl/esync_top.sv
module esync_top
    import esync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES     = 2,
    parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o,
    output logic edge_o
);

    localparam int unsigned CHAIN_LEN = SYNC_STAGES;

    // R8: chain too short to give the second flop time to settle
    generate
        if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_depth_check
            $error("esync_top: SYNC_STAGES must be at least 2");
        end
    endgenerate

    logic clr;
    logic synced;

    // R7: map the configured reset level onto an internal active-high clear
    assign clr = RST_ACTIVE_HIGH ? rst_i : !rst_i;

    esync_chain #(
        .STAGES (CHAIN_LEN)
    ) u_chain (
        .clk_i (clk_i),
        .clr_i (clr),
        .d_i   (async_i),
        .q_o   (synced)
    );

    esync_edge_fsm u_fsm (
        .clk_i   (clk_i),
        .clr_i   (clr),
        .sync_i  (synced),
        .level_o (level_o),
        .rise_o  (rise_o),
        .fall_o  (fall_o),
        .edge_o  (edge_o)
    );

    // R1: outputs are quiet in the cycle after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        clr |=> (!level_o && !edge_o));

endmodule

// File: tb/test_esync_top.sv
`timescale 1ns/1ps
module test_esync_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_n;
    logic async_in = 1'b0;

    logic a_level, a_rise, a_fall, a_edge;
    logic b_level, b_rise, b_fall, b_edge;

    int checks = 0;
    int failures = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // Arithmetic model: hist[j] = sampled input j edges ago (0 during reset)
    bit [0:7] hist = '0;
    bit prev_s = 1'b0;
    int n_rise_tr = 0, n_fall_tr = 0;
    int a_rise_n = 0, a_fall_n = 0, b_rise_n = 0, b_fall_n = 0;

    localparam int NA = 2;
    localparam int NB = 3;

    always #2 clk = ~clk;   // 250 MHz

    assign rst_n = ~rst;

    esync_top #(.SYNC_STAGES(NA), .RST_ACTIVE_HIGH(1'b1)) i_esync_top (
        .clk_i(clk), .rst_i(rst), .async_i(async_in),
        .level_o(a_level), .rise_o(a_rise), .fall_o(a_fall), .edge_o(a_edge)
    );

    esync_top #(.SYNC_STAGES(NB), .RST_ACTIVE_HIGH(1'b0)) i_esync_top_deep (
        .clk_i(clk), .rst_i(rst_n), .async_i(async_in),
        .level_o(b_level), .rise_o(b_rise), .fall_o(b_fall), .edge_o(b_edge)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each edge (inputs never change at the edge itself)
    always @(posedge clk) begin
        bit s;
        s = rst ? 1'b0 : async_in;
        if (rst) begin
            hist = '0;
            n_rise_tr = 0;
            n_fall_tr = 0;
        end else begin
            for (int j = 7; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = s;
            if (s && !prev_s) n_rise_tr++;
            if (!s && prev_s) n_fall_tr++;
        end
        prev_s = s;
    end

    // Per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (checking) begin
            chk("R2 rise_o", a_rise, int'(hist[NA-1] && !hist[NA]));
            chk("R3 fall_o", a_fall, int'(!hist[NA-1] && hist[NA]));
            chk("R4 edge_o", a_edge, int'(hist[NA-1] != hist[NA]));
            chk("R5 level_o", a_level, int'(hist[NA]));
            chk("R8 deep rise_o", b_rise, int'(hist[NB-1] && !hist[NB]));
            chk("R8 deep fall_o", b_fall, int'(!hist[NB-1] && hist[NB]));
            chk("R8 deep edge_o", b_edge, int'(hist[NB-1] != hist[NB]));
            chk("R8 deep level_o", b_level, int'(hist[NB]));
        end
        if (rst) begin
            a_rise_n = 0; a_fall_n = 0; b_rise_n = 0; b_fall_n = 0;
        end else begin
            if (a_rise === 1'b1) a_rise_n++;
            if (a_fall === 1'b1) a_fall_n++;
            if (b_rise === 1'b1) b_rise_n++;
            if (b_fall === 1'b1) b_fall_n++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic compare_counts();
        chk("R6 rise count", a_rise_n, n_rise_tr);
        chk("R6 fall count", a_fall_n, n_fall_tr);
        chk("R6 deep rise count", b_rise_n, n_rise_tr);
        chk("R6 deep fall count", b_fall_n, n_fall_tr);
    endtask

    task automatic sweep();
        for (int w = 2; w <= 6; w++) begin
            for (int g = 2; g <= 6; g++) begin
                async_in = 1'b1;
                cycles(w);
                async_in = 1'b0;
                cycles(g);
            end
        end
    endtask

    initial begin
        cycles(3);
        checking = 1'b1;
        cycles(2);
        // R1 / R7: reset state of both polarities
        @(negedge clk);
        chk("R1 level in reset", a_level, 0);
        chk("R1 edge in reset", a_edge, 0);
        chk("R7 active-low reset level", b_level, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        cycles(4);
        chk("R6 quiet input no strobe", a_rise_n + a_fall_n + b_rise_n + b_fall_n, 0);

        // Exhaustive width/gap sweep
        sweep();
        cycles(8);
        compare_counts();

        // Random toggles with widths of at least two periods
        for (int k = 0; k < 300; k++) begin
            async_in = ~async_in;
            cycles($urandom_range(2, 9));
        end
        async_in = 1'b0;
        cycles(8);
        compare_counts();

        // Mid-run reset while the input is high
        async_in = 1'b1;
        cycles(8);
        compare_counts();
        rst = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cycles(1);
            @(negedge clk);
            chk("R1 level held in reset", a_level, 0);
            chk("R1 strobe held in reset", a_edge, 0);
            chk("R7 active-low level in reset", b_level, 0);
            chk("R7 active-low strobe in reset", b_edge, 0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        cycles(8);
        sweep();
        async_in = 1'b0;
        cycles(8);
        compare_counts();

        checking = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule